// File: doc/BRIEF.md
# Flagged Arithmetic-Logic Unit with Operand Comparator

This block is a purely combinational arithmetic-logic unit for a datapath that needs a result and its status in the same cycle. Two operands and a four-bit operation code go in. A result of the operand width comes out, together with zero, negative and signed-overflow flags and a separate carry/borrow bit. The outputs follow the inputs with no register, so a surrounding pipeline can capture them on whatever edge it uses.

Sixteen operation codes are decoded. They cover additive arithmetic (including the reversed subtraction b−a), multiply, divide, reversed modulo (b%a), the five bitwise functions and the three boolean functions. The two spare codes fall back to addition. Division and modulo by zero do not trap; each gives a fixed, defined value.

The comparator outputs are independent of the operation code. They always report how `opa` relates to `opb` as unsigned numbers.

Top module: `alu_flagged`

## Requirements
- R1: `op_sel` selects the arithmetic operations as follows: 0 gives opa+opb, 1 gives opa−opb, 2 gives opb−opa, 3 gives the low WIDTH bits of opa*opb, 4 gives opa/opb (unsigned), and 5 gives opb%opa (unsigned), all modulo 2^WIDTH.
- R2: `op_sel` selects the bitwise operations as follows: 6 gives ~opa, 7 gives opa&opb, 8 gives opa|opb, 9 gives opa^opb, and 10 gives ~(opa^opb).
- R3: `op_sel` selects the boolean operations as follows: 11 gives !opa, 12 gives opa&&opb, and 13 gives opa||opb. Each result is 0 or 1; an operand counts as true when any of its bits is set.
- R4: Codes 14 and 15 produce opa+opb in `result`. For these codes `flag_ovf` and `carry_out` are 0.
- R5: `flag_zero` is 1 exactly when every bit of `result` is 0, for every code.
- R6: `flag_neg` is 1 only when `result[WIDTH-1]` is 1 and `op_sel` is 1 or 2. For every other code it is 0.
- R7: `flag_ovf` reports two's-complement signed overflow of the operation for codes 0, 1 and 2, and is 0 for every other code.
- R8: `carry_out` is bit WIDTH of the unsigned (WIDTH+1)-bit computation for codes 0, 1 and 2. That is the carry of the addition, or the borrow of the subtraction (1 when the minuend is smaller than the subtrahend). For every other code it is 0.
- R9: `cmp_lt`, `cmp_gt` and `cmp_eq` report opa<opb, opa>opb and opa==opb, with both operands taken as unsigned. Exactly one of the three is 1 at any time, for every code.
- R10: Division by zero (code 4 with opb=0) gives an all-ones result. Modulo by zero (code 5 with opa=0) gives opb. No other indication is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa | input | WIDTH | First operand |
| opb | input | WIDTH | Second operand |
| op_sel | input | 4 | Operation code |
| result | output | WIDTH | Operation result |
| flag_zero | output | 1 | Result is all zeros |
| flag_neg | output | 1 | Subtraction result has its top bit set |
| flag_ovf | output | 1 | Signed overflow of add/subtract codes |
| carry_out | output | 1 | Carry or borrow of add/subtract codes |
| cmp_lt | output | 1 | opa below opb, unsigned |
| cmp_gt | output | 1 | opa above opb, unsigned |
| cmp_eq | output | 1 | opa equal to opb |

## Verification
The bench goes after signed-overflow boundaries in both directions for all three add/subtract codes. A design that confused carry with overflow would flag 0xFFFFFFFF+1 and miss 0x7FFFFFFF+1. It also checks subtractions that land exactly on zero, where a negative flag that ignored the operation code, or a sign taken from the wrong operand of b−a, would show up at once. Division and modulo are driven with zero divisors, because a design that divided naively would produce X or the wrong fallback. The spare codes and the boolean codes are driven with multi-bit operands, which catches a decoder that mixes bitwise and boolean forms or flags overflow on the fallback addition.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_RSUB = 4'd2,
        OP_MUL  = 4'd3,
        OP_DIV  = 4'd4,
        OP_RMOD = 4'd5,
        OP_NOT  = 4'd6,
        OP_AND  = 4'd7,
        OP_OR   = 4'd8,
        OP_XOR  = 4'd9,
        OP_XNOR = 4'd10,
        OP_LNOT = 4'd11,
        OP_LAND = 4'd12,
        OP_LOR  = 4'd13,
        OP_SPR0 = 4'd14,
        OP_SPR1 = 4'd15
    } alu_op_e;

    localparam int OP_W = 4;

endpackage

// File: rtl/alu_arith.sv
module alu_arith
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    input  alu_op_e          op,
    output logic [WIDTH-1:0] arith_res,
    output logic             carry,
    output logic             ovf
);
    localparam int               MSB      = WIDTH - 1;
    localparam logic [WIDTH-1:0] ALL_ONES = '1;

    logic [WIDTH:0] sum_x;
    logic [WIDTH:0] dif_ab;
    logic [WIDTH:0] dif_ba;
    logic           sa;
    logic           sb;

    assign sum_x  = {1'b0, opa} + {1'b0, opb};
    assign dif_ab = {1'b0, opa} - {1'b0, opb};
    assign dif_ba = {1'b0, opb} - {1'b0, opa};
    assign sa     = opa[MSB];
    assign sb     = opb[MSB];

    always_comb begin
        arith_res = sum_x[MSB:0];
        carry     = 1'b0;
        ovf       = 1'b0;
        unique case (op)
            OP_ADD: begin
                arith_res = sum_x[MSB:0];
                carry     = sum_x[WIDTH];
                ovf       = (sa == sb) && (sum_x[MSB] != sa);
            end
            OP_SUB: begin
                arith_res = dif_ab[MSB:0];
                carry     = dif_ab[WIDTH];
                ovf       = (sa != sb) && (dif_ab[MSB] != sa);
            end
            OP_RSUB: begin
                arith_res = dif_ba[MSB:0];
                carry     = dif_ba[WIDTH];
                ovf       = (sa != sb) && (dif_ba[MSB] != sb);
            end
            OP_MUL:  arith_res = opa * opb;
            OP_DIV:  arith_res = (opb == '0) ? ALL_ONES : (opa / opb);
            OP_RMOD: arith_res = (opa == '0) ? opb : (opb % opa);
            OP_NOT, OP_AND, OP_OR, OP_XOR, OP_XNOR,
            OP_LNOT, OP_LAND, OP_LOR, OP_SPR0, OP_SPR1:
                arith_res = sum_x[MSB:0];
        endcase
    end

    // R1: addition and subtraction must invert each other
    always_comb begin
        if (!$isunknown({opa, opb, op})) begin
            if (op == OP_ADD) begin
                p_add_inverse_r1: assert ((arith_res - opb) == opa);
            end
            if (op == OP_SUB) begin
                p_sub_inverse_r1: assert ((arith_res + opb) == opa);
            end
        end
    end

endmodule

// File: rtl/alu_logic.sv
module alu_logic
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    input  alu_op_e          op,
    output logic [WIDTH-1:0] logic_res
);
    localparam int PAD = WIDTH - 1;

    logic ta;
    logic tb;

    assign ta = |opa;
    assign tb = |opb;

    always_comb begin
        logic_res = '0;
        unique case (op)
            OP_NOT:  logic_res = ~opa;
            OP_AND:  logic_res = opa & opb;
            OP_OR:   logic_res = opa | opb;
            OP_XOR:  logic_res = opa ^ opb;
            OP_XNOR: logic_res = ~(opa ^ opb);
            OP_LNOT: logic_res = {{PAD{1'b0}}, ~ta};
            OP_LAND: logic_res = {{PAD{1'b0}}, ta & tb};
            OP_LOR:  logic_res = {{PAD{1'b0}}, ta | tb};
            OP_ADD, OP_SUB, OP_RSUB, OP_MUL, OP_DIV,
            OP_RMOD, OP_SPR0, OP_SPR1:
                logic_res = '0;
        endcase
    end

endmodule

// File: rtl/alu_compare.sv
module alu_compare #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    output logic             lt,
    output logic             gt,
    output logic             eq
);
    assign lt = opa < opb;
    assign gt = opa > opb;
    assign eq = opa == opb;

    // R9: exactly one relation holds
    always_comb begin
        if (!$isunknown({opa, opb})) begin
            p_cmp_onehot_r9: assert ($countones({lt, gt, eq}) == 1);
        end
    end

endmodule

// File: rtl/alu_flagged.sv
module alu_flagged
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    input  logic [3:0]       op_sel,
    output logic [WIDTH-1:0] result,
    output logic             flag_zero,
    output logic             flag_neg,
    output logic             flag_ovf,
    output logic             carry_out,
    output logic             cmp_lt,
    output logic             cmp_gt,
    output logic             cmp_eq
);
    localparam int MSB = WIDTH - 1;

    alu_op_e          op;
    logic [WIDTH-1:0] arith_res;
    logic [WIDTH-1:0] logic_res;
    logic             a_carry;
    logic             a_ovf;
    logic             is_logic;
    logic             is_sub;

    assign op = alu_op_e'(op_sel);

    alu_arith #(.WIDTH(WIDTH)) u_arith (
        .opa       (opa),
        .opb       (opb),
        .op        (op),
        .arith_res (arith_res),
        .carry     (a_carry),
        .ovf       (a_ovf)
    );

    alu_logic #(.WIDTH(WIDTH)) u_logic (
        .opa       (opa),
        .opb       (opb),
        .op        (op),
        .logic_res (logic_res)
    );

    alu_compare #(.WIDTH(WIDTH)) u_cmp (
        .opa (opa),
        .opb (opb),
        .lt  (cmp_lt),
        .gt  (cmp_gt),
        .eq  (cmp_eq)
    );

    always_comb begin
        is_logic = 1'b0;
        is_sub   = 1'b0;
        unique case (op)
            OP_NOT, OP_AND, OP_OR, OP_XOR, OP_XNOR,
            OP_LNOT, OP_LAND, OP_LOR:  is_logic = 1'b1;
            OP_SUB, OP_RSUB:           is_sub   = 1'b1;
            OP_ADD, OP_MUL, OP_DIV, OP_RMOD,
            OP_SPR0, OP_SPR1:          is_logic = 1'b0;
        endcase
    end

    always_comb begin
        result    = is_logic ? logic_res : arith_res;
        flag_zero = (result == '0);
        flag_neg  = is_sub & result[MSB];
        flag_ovf  = a_ovf;
        carry_out = a_carry;
    end

    always_comb begin
        if (!$isunknown({opa, opb, op_sel})) begin
            // R5: a zero result can never look negative
            p_zero_not_neg_r5: assert (!(flag_zero && flag_neg));
            // R6: negative only on subtraction codes
            p_neg_sub_only_r6: assert (!flag_neg || op_sel == 4'd1 || op_sel == 4'd2);
            // R7: overflow only on add/subtract codes
            p_no_overflow_r7: assert (!flag_ovf || op_sel <= 4'd2);
            // R8: carry only on add/subtract codes
            p_carry_scope_r8: assert (!carry_out || op_sel <= 4'd2);
            // R3: boolean codes give 0 or 1
            if (op_sel >= 4'd11 && op_sel <= 4'd13) begin
                p_logical_bool_r3: assert (result <= 1);
            end
        end
    end

endmodule

// File: tb/tb_alu_flagged.sv
module tb_alu_flagged;

    logic        clk = 1'b0;
    logic [31:0] opa = '0;
    logic [31:0] opb = '0;
    logic [3:0]  op_sel = '0;
    logic [31:0] result;
    logic        flag_zero, flag_neg, flag_ovf, carry_out;
    logic        cmp_lt, cmp_gt, cmp_eq;

    int vectors = 0;
    int fails   = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    alu_flagged #(.WIDTH(32)) dut (
        .opa (opa), .opb (opb), .op_sel (op_sel),
        .result (result), .flag_zero (flag_zero), .flag_neg (flag_neg),
        .flag_ovf (flag_ovf), .carry_out (carry_out),
        .cmp_lt (cmp_lt), .cmp_gt (cmp_gt), .cmp_eq (cmp_eq)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // independent model written from the requirement text
    task automatic apply_and_check(input logic [31:0] a, input logic [31:0] b,
                                   input logic [3:0] op, input string tag);
        logic [31:0] r;
        logic        c, v;
        longint      sa, sb, s;
        logic [63:0] u;
        sa = longint'(signed'(a));
        sb = longint'(signed'(b));
        s  = 0;
        c  = 1'b0;
        case (op)
            4'd0:  begin u = {32'd0, a} + {32'd0, b}; r = u[31:0]; c = u[32]; s = sa + sb; end
            4'd1:  begin r = a - b; c = (a < b); s = sa - sb; end
            4'd2:  begin r = b - a; c = (b < a); s = sb - sa; end
            4'd3:  begin u = {32'd0, a} * {32'd0, b}; r = u[31:0]; end
            4'd4:  r = (b == 0) ? 32'hFFFF_FFFF : a / b;
            4'd5:  r = (a == 0) ? b : b % a;
            4'd6:  r = ~a;
            4'd7:  r = a & b;
            4'd8:  r = a | b;
            4'd9:  r = a ^ b;
            4'd10: r = ~(a ^ b);
            4'd11: r = (a == 0) ? 32'd1 : 32'd0;
            4'd12: r = (a != 0 && b != 0) ? 32'd1 : 32'd0;
            4'd13: r = (a != 0 || b != 0) ? 32'd1 : 32'd0;
            default: r = a + b;
        endcase
        v = (op <= 4'd2) && (s > 64'sd2147483647 || s < -64'sd2147483648);
        @(negedge clk);
        opa = a; opb = b; op_sel = op;
        #2;
        chk(tag, "result", result, r);
        chk("R5", "flag_zero", {31'd0, flag_zero}, {31'd0, r == 0});
        chk("R6", "flag_neg", {31'd0, flag_neg}, {31'd0, r[31] && (op == 1 || op == 2)});
        chk("R7", "flag_ovf", {31'd0, flag_ovf}, {31'd0, v});
        chk("R8", "carry_out", {31'd0, carry_out}, {31'd0, c});
        chk("R9", "cmp", {29'd0, cmp_lt, cmp_gt, cmp_eq},
            {29'd0, a < b, a > b, a == b});
    endtask

    task automatic t_idle;   // all-zero inputs
        @(negedge clk); #2;
        chk("R5", "idle zero", {31'd0, flag_zero}, 32'd1);
        chk("R9", "idle eq", {29'd0, cmp_lt, cmp_gt, cmp_eq}, 32'd1);
        chk("R1", "idle result", result, 32'd0);
    endtask

    task automatic t_arith;  // R1
        apply_and_check(32'd45, 32'd75, 4'd0, "R1");
        apply_and_check(32'd120, 32'd25, 4'd1, "R1");
        apply_and_check(32'd30, 32'd120, 4'd2, "R1");
        apply_and_check(32'h0001_0003, 32'h0002_0005, 4'd3, "R1");
        apply_and_check(32'd75, 32'd3, 4'd4, "R1");
        apply_and_check(32'd3, 32'd74, 4'd5, "R1");
        chk("R1", "rmod literal", result, 32'd2);
    endtask

    task automatic t_bitwise;  // R2
        for (int k = 6; k <= 10; k++)
            apply_and_check(32'hF0F0_1234, 32'h0FF0_00FF, 4'(k), "R2");
    endtask

    task automatic t_logical;  // R3
        for (int k = 11; k <= 13; k++) begin
            apply_and_check(32'h0000_0100, 32'h0, 4'(k), "R3");
            apply_and_check(32'h0, 32'h8000_0000, 4'(k), "R3");
            apply_and_check(32'h0000_0002, 32'h0000_0004, 4'(k), "R3");
        end
    endtask

    task automatic t_spare;  // R4
        apply_and_check(32'h7FFF_FFFF, 32'd1, 4'd14, "R4");
        apply_and_check(32'hFFFF_FFFF, 32'd1, 4'd15, "R4");
        chk("R4", "spare ovf/carry", {30'd0, flag_ovf, carry_out}, 32'd0);
    endtask

    task automatic t_flags;  // R5 R6 R7 R8
        apply_and_check(32'd1, 32'd1, 4'd1, "R5");
        apply_and_check(32'd1, 32'd2, 4'd1, "R6");
        apply_and_check(32'd2, 32'd1, 4'd2, "R6");
        apply_and_check(32'h8000_0000, 32'd0, 4'd0, "R6");
        apply_and_check(32'h7FFF_FFFF, 32'd1, 4'd0, "R7");
        chk("R7", "pos ovf literal", {31'd0, flag_ovf}, 32'd1);
        apply_and_check(32'hFFFF_FFFF, 32'd1, 4'd0, "R8");
        chk("R8", "carry literal", {30'd0, flag_ovf, carry_out}, 32'd1);
        apply_and_check(32'h8000_0000, 32'd1, 4'd1, "R7");
        apply_and_check(32'h8000_0000, 32'd1, 4'd2, "R7");
        apply_and_check(32'd1, 32'h8000_0000, 4'd2, "R7");
        apply_and_check(32'h7FFF_FFFF, 32'h7FFF_FFFF, 4'd3, "R7");
    endtask

    task automatic t_divzero;  // R10
        apply_and_check(32'd1234, 32'd0, 4'd4, "R10");
        chk("R10", "div0 literal", result, 32'hFFFF_FFFF);
        apply_and_check(32'd0, 32'd987, 4'd5, "R10");
        chk("R10", "mod0 literal", result, 32'd987);
    endtask

    task automatic t_compare;  // R9
        apply_and_check(32'hFFFF_FFFF, 32'd1, 4'd7, "R9");
        apply_and_check(32'd5, 32'h8000_0000, 4'd9, "R9");
        apply_and_check(32'hDEAD_BEEF, 32'hDEAD_BEEF, 4'd3, "R9");
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    endtask

    initial begin
        t_idle();
        t_arith();
        t_bitwise();
        t_logical();
        t_spare();
        t_flags();
        t_divzero();
        t_compare();
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

endmodule